// File: doc/BRIEF.md
# Debug breakpoint and halt unit

This unit sits next to a small 8-bit controller core and decides when the core must stop. It keeps a short list of breakpoint addresses in program memory. Software or a debug host manages the list through a command port with four operations: add, remove, toggle and empty. A command that names an address beyond the configured program memory, or that removes an address the list does not hold, raises a one-cycle error pulse.

Each time the core retires an instruction, the unit compares the program counter that follows the instruction with four halt conditions in the same cycle:
- every breakpoint in the list, using parallel comparators;
- a separate stop address, which is active only when it is nonzero;
- an instruction budget that was loaded at the start of the run;
- an external break request.

A fetch from outside program memory also stops the run. When a run stops, the unit raises a halt request and reports the cause as a one-hot code. That code is held until the next run is started.

Top module: `dbg_halt_unit`

## Requirements
- R1: After reset, halt, halt_cause and cmd_err are all 0 and the breakpoint list is empty, so no retired program counter causes a halt.
- R2: An add (cmd_op 0) or toggle (cmd_op 2) whose address is at or above PMEM_SIZE (default 4096) sets cmd_err for one cycle, the cycle after the command, and does not change the list.
- R3: An add is silently ignored, with cmd_err kept at 0, when the address is already in the list or when the list already holds DEPTH (default 8) entries.
- R4: A remove (cmd_op 1) of an address that is not in the list pulses cmd_err and changes nothing. A remove of a listed address deletes only that address; every other entry stays listed.
- R5: A toggle of an address in the list removes it. A toggle of any other address behaves exactly as an add.
- R6: An empty command (cmd_op 3) leaves the list with no entries from the next cycle on.
- R7: While running, a retire whose retire_pc equals a listed address halts the core in the next cycle with halt_cause 5'b01000.
- R8: A retire whose retire_pc equals a nonzero stop_addr halts with halt_cause 5'b00100. A stop_addr of 0 never matches.
- R9: run_start loads budget_in as a signed value. If the value N is positive, the Nth following retire halts with halt_cause 5'b10000. If the value is zero or negative, there is no budget limit.
- R10: ext_break that is high during a retire halts with halt_cause 5'b00010. ext_break without a retire has no effect.
- R11: While running, fetch_valid with fetch_addr at or above PMEM_SIZE halts with halt_cause 5'b00001.
- R12: When several causes occur in the same cycle, only the highest-priority one is reported. The order from highest to lowest is budget, breakpoint, stop, external, fetch error. halt and halt_cause then hold, ignoring retires, until run_start clears them. Retires before any run_start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | A list command is present this cycle |
| cmd_op | input | 2 | 0 add, 1 remove, 2 toggle, 3 empty |
| cmd_addr | input | AW | Address operand of the command |
| cmd_err | output | 1 | One-cycle pulse: command rejected |
| stop_addr | input | AW | Stop address; 0 disables it |
| run_start | input | 1 | Starts a run: loads budget, clears halt |
| budget_in | input | BW | Signed instruction budget |
| retire_valid | input | 1 | An instruction retired this cycle |
| retire_pc | input | AW | Program counter after the retired instruction |
| ext_break | input | 1 | External break request, sampled on retire |
| fetch_valid | input | 1 | The core fetches this cycle |
| fetch_addr | input | AW | Fetch address |
| halt | output | 1 | Halt request to the core |
| halt_cause | output | 5 | {budget, breakpoint, stop, external, fetch_error} |

## Verification
The bench keeps its own model of which addresses are listed. After each phase of list traffic it sweeps the same twelve probe addresses through a one-retire run and compares each halt with the model:
- filling the list and adding one more separates the full-list rule from ordinary adds;
- a repeated add followed by a single remove shows whether duplicates were stored;
- removing from the middle of the list shows whether the other entries survive.

The remaining patterns each isolate one halt cause or one ordering:
- budgets of 3, 0 and negative values;
- a zero stop address at program counter 0;
- an external break with and without a retire;
- fetches just below and at the program memory limit;
- one retire that carries several causes at once, which exposes the priority order.

// File: rtl/dbg_halt_pkg.sv
package dbg_halt_pkg;

    typedef enum logic [1:0] {
        OP_ADD    = 2'd0,
        OP_REMOVE = 2'd1,
        OP_TOGGLE = 2'd2,
        OP_EMPTY  = 2'd3
    } bp_op_e;

    localparam int CAUSE_W   = 5;
    localparam int CB_BUDGET = 4;
    localparam int CB_BKPT   = 3;
    localparam int CB_STOP   = 2;
    localparam int CB_EXT    = 1;
    localparam int CB_FETCH  = 0;

endpackage

// File: rtl/dbg_bp_list.sv
module dbg_bp_list
    import dbg_halt_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int PMEM_SIZE = 4096,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int IW       = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    output logic          cmd_err,
    input  logic [AW-1:0] match_addr,
    output logic          match_hit,
    output logic [CW-1:0] count
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] ent;
        logic [CW-1:0]            cnt;
        logic                     err;
    } list_t;

    list_t list_d, list_q;

    logic [DEPTH-1:0] cmd_hit;
    logic [DEPTH-1:0] pc_hit;

    // Two parallel comparator banks: one for the command, one for the PC.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign cmd_hit[g] = (CW'(g) < list_q.cnt) && (list_q.ent[g] == cmd_addr);
        assign pc_hit[g]  = (CW'(g) < list_q.cnt) && (list_q.ent[g] == match_addr);
    end

    logic          present;
    logic          full;
    logic          out_of_range;
    logic [IW-1:0] hit_idx;
    logic          do_add;
    logic          do_del;
    bp_op_e        op;

    always_comb begin
        op           = bp_op_e'(cmd_op);
        present      = |cmd_hit;
        full         = (list_q.cnt == CW'(DEPTH));
        out_of_range = ({1'b0, cmd_addr} >= (AW + 1)'(PMEM_SIZE));
        hit_idx      = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (cmd_hit[i]) hit_idx = IW'(i);
        end

        list_d     = list_q;
        list_d.err = 1'b0;
        do_add     = 1'b0;
        do_del     = 1'b0;

        if (cmd_valid) begin
            case (op)
                OP_ADD: begin
                    if (out_of_range)          list_d.err = 1'b1;
                    else if (!present && !full) do_add = 1'b1;
                end
                OP_REMOVE: begin
                    if (out_of_range || !present) list_d.err = 1'b1;
                    else                          do_del = 1'b1;
                end
                OP_TOGGLE: begin
                    if (out_of_range)  list_d.err = 1'b1;
                    else if (present)  do_del = 1'b1;
                    else if (!full)    do_add = 1'b1;
                end
                default: list_d.cnt = '0;
            endcase
        end

        if (do_add) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == list_q.cnt) list_d.ent[i] = cmd_addr;
            end
            list_d.cnt = list_q.cnt + 1'b1;
        end

        if (do_del) begin
            // Last valid entry moves into the freed slot; list stays packed.
            for (int i = 0; i < DEPTH; i++) begin
                if (IW'(i) == hit_idx) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        if (CW'(j) == list_q.cnt - 1'b1) list_d.ent[i] = list_q.ent[j];
                    end
                end
            end
            list_d.cnt = list_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) list_q <= '0;
        else        list_q <= list_d;
    end

    assign cmd_err   = list_q.err;
    assign match_hit = |pc_hit;
    assign count     = list_q.cnt;

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_halt_pkg::*;
#(
    parameter int AW        = 16,
    parameter int BW        = 16,
    parameter int PMEM_SIZE = 4096
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_start,
    input  logic [BW-1:0]      budget_in,
    input  logic               retire_valid,
    input  logic [AW-1:0]      retire_pc,
    input  logic               bp_hit,
    input  logic [AW-1:0]      stop_addr,
    input  logic               ext_break,
    input  logic               fetch_valid,
    input  logic [AW-1:0]      fetch_addr,
    output logic               halt,
    output logic [CAUSE_W-1:0] halt_cause
);

    typedef struct packed {
        logic               run;
        logic               lim;
        logic [BW-1:0]      left;
        logic               halt;
        logic [CAUSE_W-1:0] cause;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [CAUSE_W-1:0] hits;
    logic [CAUSE_W-1:0] sel;
    logic               fetch_bad;

    always_comb begin
        fetch_bad = ({1'b0, fetch_addr} >= (AW + 1)'(PMEM_SIZE));
        hits      = '0;
        sel       = '0;
        ctrl_d    = ctrl_q;

        if (run_start) begin
            ctrl_d.run   = 1'b1;
            ctrl_d.halt  = 1'b0;
            ctrl_d.cause = '0;
            ctrl_d.lim   = ($signed(budget_in) > 0);
            ctrl_d.left  = budget_in;
        end else if (ctrl_q.run) begin
            if (retire_valid) begin
                if (ctrl_q.lim) ctrl_d.left = ctrl_q.left - 1'b1;
                hits[CB_BUDGET] = ctrl_q.lim && (ctrl_q.left == BW'(1));
                hits[CB_BKPT]   = bp_hit;
                hits[CB_STOP]   = (stop_addr != '0) && (stop_addr == retire_pc);
                hits[CB_EXT]    = ext_break;
            end
            hits[CB_FETCH] = fetch_valid && fetch_bad;

            // Highest bit wins: budget, breakpoint, stop, external, fetch.
            for (int i = 0; i < CAUSE_W; i++) begin
                if (hits[i]) sel = CAUSE_W'(1) << i;
            end

            if (|hits) begin
                ctrl_d.run   = 1'b0;
                ctrl_d.halt  = 1'b1;
                ctrl_d.cause = sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign halt       = ctrl_q.halt;
    assign halt_cause = ctrl_q.cause;

endmodule

// File: rtl/dbg_halt_unit.sv
module dbg_halt_unit
    import dbg_halt_pkg::*;
#(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int PMEM_SIZE = 4096,
    parameter int BW        = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_op,
    input  logic [AW-1:0]      cmd_addr,
    output logic               cmd_err,
    input  logic [AW-1:0]      stop_addr,
    input  logic               run_start,
    input  logic [BW-1:0]      budget_in,
    input  logic               retire_valid,
    input  logic [AW-1:0]      retire_pc,
    input  logic               ext_break,
    input  logic               fetch_valid,
    input  logic [AW-1:0]      fetch_addr,
    output logic               halt,
    output logic [CAUSE_W-1:0] halt_cause
);

    localparam int CW = $clog2(DEPTH + 1);

    logic          bp_hit;
    logic [CW-1:0] bp_count;

    dbg_bp_list #(
        .AW(AW), .DEPTH(DEPTH), .PMEM_SIZE(PMEM_SIZE)
    ) u_list (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_addr   (cmd_addr),
        .cmd_err    (cmd_err),
        .match_addr (retire_pc),
        .match_hit  (bp_hit),
        .count      (bp_count)
    );

    dbg_halt_ctrl #(
        .AW(AW), .BW(BW), .PMEM_SIZE(PMEM_SIZE)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_start    (run_start),
        .budget_in    (budget_in),
        .retire_valid (retire_valid),
        .retire_pc    (retire_pc),
        .bp_hit       (bp_hit),
        .stop_addr    (stop_addr),
        .ext_break    (ext_break),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .halt         (halt),
        .halt_cause   (halt_cause)
    );

endmodule

// File: rtl/dbg_halt_checker.sv
module dbg_halt_checker #(
    parameter int AW        = 16,
    parameter int DEPTH     = 8,
    parameter int PMEM_SIZE = 4096,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cmd_valid,
    input logic [1:0]    cmd_op,
    input logic [AW-1:0] cmd_addr,
    input logic          cmd_err,
    input logic          run_start,
    input logic          retire_valid,
    input logic          fetch_valid,
    input logic          halt,
    input logic [4:0]    halt_cause,
    input logic [CW-1:0] bp_count
);

    logic oor;
    assign oor = ({1'b0, cmd_addr} >= (AW + 1)'(PMEM_SIZE));

    assert_err_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'd0) && oor) |=> (cmd_err && $stable(bp_count)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bp_count <= CW'(DEPTH));

    assert_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == 2'd3)) |=> (bp_count == '0));

    assert_cause_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(halt_cause));

    assert_cause_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !run_start) |=> (halt && $stable(halt_cause)));

    assert_halt_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(retire_valid || fetch_valid));

endmodule

bind dbg_halt_unit dbg_halt_checker #(
    .AW(AW), .DEPTH(DEPTH), .PMEM_SIZE(PMEM_SIZE)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_op       (cmd_op),
    .cmd_addr     (cmd_addr),
    .cmd_err      (cmd_err),
    .run_start    (run_start),
    .retire_valid (retire_valid),
    .fetch_valid  (fetch_valid),
    .halt         (halt),
    .halt_cause   (halt_cause),
    .bp_count     (bp_count)
);

// File: tb/test_dbg_halt_unit.sv
module test_dbg_halt_unit;

    localparam int AW = 16, DEPTH = 8, PMEM = 4096, BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic          cmd_err;
    logic [AW-1:0] stop_addr = '0;
    logic          run_start = 1'b0;
    logic [BW-1:0] budget_in = '0;
    logic          retire_valid = 1'b0;
    logic [AW-1:0] retire_pc = '0;
    logic          ext_break = 1'b0;
    logic          fetch_valid = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          halt;
    logic [4:0]    halt_cause;

    always #10 clk = ~clk;

    dbg_halt_unit #(.AW(AW), .DEPTH(DEPTH), .PMEM_SIZE(PMEM), .BW(BW)) i_dbg_halt_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_err(cmd_err), .stop_addr(stop_addr),
        .run_start(run_start), .budget_in(budget_in), .retire_valid(retire_valid),
        .retire_pc(retire_pc), .ext_break(ext_break), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .halt(halt), .halt_cause(halt_cause)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [AW-1:0] m_ent [DEPTH];
    int            m_cnt = 0;

    function automatic int m_find(logic [AW-1:0] a);
        for (int i = 0; i < m_cnt; i++) if (m_ent[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [AW-1:0] probe_addr(int k);
        return AW'(16'h0040 * k + 16'h0005);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Issue one command; model the expected list and error from the requirements.
    task automatic cmd(logic [1:0] op, logic [AW-1:0] a, string tag);
        bit oor, exp_err;
        int idx;
        oor = (a >= AW'(PMEM));
        idx = m_find(a);
        exp_err = 1'b0;
        case (op)
            2'd0: if (oor) exp_err = 1; else if (idx < 0 && m_cnt < DEPTH) begin m_ent[m_cnt] = a; m_cnt++; end
            2'd1: if (oor || idx < 0) exp_err = 1; else begin m_ent[idx] = m_ent[m_cnt-1]; m_cnt--; end
            2'd2: if (oor) exp_err = 1;
                  else if (idx >= 0) begin m_ent[idx] = m_ent[m_cnt-1]; m_cnt--; end
                  else if (m_cnt < DEPTH) begin m_ent[m_cnt] = a; m_cnt++; end
            default: m_cnt = 0;
        endcase
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(tag, {31'd0, cmd_err}, {31'd0, exp_err});
    endtask

    task automatic start(int b);
        run_start = 1'b1; budget_in = BW'(b);
        @(negedge clk);
        run_start = 1'b0;
    endtask

    task automatic retire(logic [AW-1:0] pc, logic ext);
        retire_valid = 1'b1; retire_pc = pc; ext_break = ext;
        @(negedge clk);
        retire_valid = 1'b0; ext_break = 1'b0;
    endtask

    // R7: one-retire run at each probe address; halt iff the model lists it.
    task automatic sweep(string tag);
        for (int k = 0; k < 12; k++) begin
            logic [AW-1:0] pc;
            pc = probe_addr(k);
            start(0);
            retire(pc, 1'b0);
            chk(tag, {27'd0, halt_cause}, (m_find(pc) >= 0) ? 32'h08 : 32'h00);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 halt", {31'd0, halt}, 0);
        chk("R1 cause", {27'd0, halt_cause}, 0);
        chk("R1 err", {31'd0, cmd_err}, 0);
        sweep("R1 empty list sweep");

        cmd(2'd0, 16'h1000, "R2 add at limit");
        cmd(2'd0, 16'hFFFF, "R2 add top");
        cmd(2'd2, 16'h1234, "R2 toggle out of range");
        for (int k = 0; k < 8; k++) cmd(2'd0, probe_addr(k), "R3 fill");
        cmd(2'd0, probe_addr(8), "R3 add when full");
        cmd(2'd0, probe_addr(2), "R3 duplicate when full");
        sweep("R3 full list sweep");

        cmd(2'd1, probe_addr(3), "R4 remove middle");
        cmd(2'd1, probe_addr(3), "R4 remove absent");
        cmd(2'd1, probe_addr(10), "R4 remove never listed");
        cmd(2'd0, probe_addr(9), "R3 add after free");
        cmd(2'd0, probe_addr(9), "R3 duplicate add");
        cmd(2'd1, probe_addr(9), "R3 single remove of dup");
        sweep("R4 sweep after removes");

        cmd(2'd2, probe_addr(0), "R5 toggle present");
        cmd(2'd2, probe_addr(11), "R5 toggle absent");
        cmd(2'd2, probe_addr(3), "R5 toggle absent 2");
        sweep("R5 sweep after toggles");

        cmd(2'd3, 16'h0000, "R6 empty");
        sweep("R6 sweep after empty");

        // R8 stop address
        stop_addr = 16'h0200;
        start(0); retire(16'h0200, 1'b0);
        chk("R8 stop match", {27'd0, halt_cause}, 32'h04);
        start(0); retire(16'h0201, 1'b0);
        chk("R8 stop mismatch", {31'd0, halt}, 0);
        stop_addr = 16'h0000;
        start(0); retire(16'h0000, 1'b0);
        chk("R8 zero stop disabled", {31'd0, halt}, 0);

        // R9 budget
        start(3); retire(16'h0300, 0); retire(16'h0301, 0);
        chk("R9 budget before end", {31'd0, halt}, 0);
        retire(16'h0302, 0);
        chk("R9 budget reached", {27'd0, halt_cause}, 32'h10);
        start(0); for (int i = 0; i < 5; i++) retire(16'h0300, 0);
        chk("R9 zero budget unlimited", {31'd0, halt}, 0);
        start(-2); for (int i = 0; i < 5; i++) retire(16'h0300, 0);
        chk("R9 negative budget unlimited", {31'd0, halt}, 0);

        // R10 external break
        start(0);
        ext_break = 1'b1; @(negedge clk); ext_break = 1'b0;
        chk("R10 ext without retire", {31'd0, halt}, 0);
        retire(16'h0300, 1'b1);
        chk("R10 ext on retire", {27'd0, halt_cause}, 32'h02);

        // R11 fetch error
        start(0);
        fetch_valid = 1'b1; fetch_addr = 16'h0FFF; @(negedge clk);
        chk("R11 fetch in range", {31'd0, halt}, 0);
        fetch_addr = 16'h1000; @(negedge clk); fetch_valid = 1'b0;
        chk("R11 fetch beyond", {27'd0, halt_cause}, 32'h01);

        // R12 priority, hold and idle
        cmd(2'd0, 16'h0400, "R12 setup");
        stop_addr = 16'h0400;
        start(1);
        fetch_valid = 1'b1; fetch_addr = 16'hF000;
        retire(16'h0400, 1'b1);
        fetch_valid = 1'b0;
        chk("R12 budget first", {27'd0, halt_cause}, 32'h10);
        start(0);
        fetch_valid = 1'b1; fetch_addr = 16'hF000;
        retire(16'h0400, 1'b1);
        fetch_valid = 1'b0;
        chk("R12 breakpoint over stop", {27'd0, halt_cause}, 32'h08);
        cmd(2'd1, 16'h0400, "R12 remove");
        start(0); retire(16'h0400, 1'b1);
        chk("R12 stop over ext", {27'd0, halt_cause}, 32'h04);
        stop_addr = 16'h0000;
        retire(16'h0000, 1'b1);
        chk("R12 cause held", {27'd0, halt_cause}, 32'h04);
        chk("R12 halt held", {31'd0, halt}, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule